// File: doc/BRIEF.md
# PCI Even-Parity Generator and Checker

This block produces and verifies the single parity bit that accompanies the 32 address/data lines and 4 command/byte-enable lines of a PCI agent. On the drive side it computes even parity over every one of the 36 lines, whether or not a byte lane carries useful data. It presents that bit one clock after the word it covers. Its output enable follows the address/data enable with the same one-clock delay.

On the receive side it recomputes parity from the sampled lines and holds the result for one clock. On the next edge it compares that result with the parity bit received then. A comparison is made only when the sampled cycle was an address phase, or a data beat in which both IRDY and TRDY were asserted and this agent took part. Each mismatch gives a one-cycle error pulse, a flag that tells address errors from data errors, and a sticky detected-parity-error status bit. Software clears the status bit by writing one to it.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_out` equals the XOR of all 32 bits of `ad_out` and all 4 bits of `cbe_out`, so the count of ones over the 36 lines plus the parity bit is even.
- R2: `par_out` and `par_oe` change on the clock edge after the word they cover: `par_oe` is `ad_oe` delayed by exactly one clock.
- R3: Every C/BE line counts toward parity on both sides, including lanes with no data. With `ad_out` = 0 and `cbe_out` = 4'b0001, `par_out` is 1.
- R4: When `addr_phase` is 1 in cycle N, the line parity sampled in cycle N is compared with `par_in` in cycle N+1. On a mismatch, `perr_pulse` and `perr_is_addr` are both 1 during the cycle after that edge.
- R5: When `addr_phase` is 0 and `irdy`, `trdy` and `agent_sel` are all 1 in cycle N, the same comparison is made. On a mismatch, `perr_pulse` is 1 and `perr_is_addr` is 0.
- R6: A cycle that meets neither condition is not checked. A wrong parity bit after it raises no pulse and leaves `dpe_status` unchanged.
- R7: A detected mismatch sets `dpe_status`, which stays 1 until it is cleared.
- R8: A cycle with `stat_wr` = 1 and `stat_wdata` = 1 clears `dpe_status` at the next edge. With `stat_wdata` = 0 the write has no effect.
- R9: When a new mismatch and a clearing write land on the same edge, `dpe_status` ends at 1.
- R10: After reset, `par_out`, `par_oe`, `perr_pulse`, `perr_is_addr` and `dpe_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_out | input | 32 | Address/data word this agent drives |
| cbe_out | input | 4 | Command/byte-enable value this agent drives |
| ad_oe | input | 1 | Agent drives AD this cycle |
| par_out | output | 1 | Generated parity, one clock late |
| par_oe | output | 1 | Enable for the parity driver |
| ad_in | input | 32 | Sampled address/data lines |
| cbe_in | input | 4 | Sampled command/byte-enable lines |
| par_in | input | 1 | Sampled parity line |
| addr_phase | input | 1 | Current cycle is an address phase |
| irdy | input | 1 | Initiator ready (active high) |
| trdy | input | 1 | Target ready (active high) |
| agent_sel | input | 1 | This agent takes part in the current transfer |
| stat_wr | input | 1 | Write strobe to the status bit |
| stat_wdata | input | 1 | Write data; 1 clears the status bit |
| perr_pulse | output | 1 | One-cycle pulse for each detected mismatch |
| perr_is_addr | output | 1 | With the pulse: 1 for an address error, 0 for a data error |
| dpe_status | output | 1 | Sticky detected-parity-error bit |

## Verification
The drive side is given random words with random enables, plus a directed word in which only one C/BE bit is set. That word shows whether the lanes without data are really included. The receive side runs a random stream of beats mixing address phases, completed data beats and beats missing one of IRDY, TRDY or agent select. Bit flips on the delayed parity line tell a correctly qualified check apart from one that fires on every cycle or on the wrong beat. Random clearing writes, and a directed case where a clear meets a new error, separate the sticky set, the write-one clear and the priority between them.

// File: rtl/pci_parity_pkg.sv
package pci_parity_pkg;
  localparam int AD_W  = 32;
  localparam int CBE_W = 4;

  // Even parity bit over the full address/data and command/byte-enable set.
  function automatic logic even_par(input logic [AD_W-1:0] ad, input logic [CBE_W-1:0] cbe);
    return ^{ad, cbe};
  endfunction
endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen
  import pci_parity_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_out,
  input  logic [CBE_W-1:0] cbe_out,
  input  logic             ad_oe,
  output logic             par_out,
  output logic             par_oe
);
  // The parity trails its word by one clock, and so does its enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
    end else begin
      par_out <= even_par(ad_out, cbe_out);
      par_oe  <= ad_oe;
    end
  end
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
  import pci_parity_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             addr_phase,
  input  logic             irdy,
  input  logic             trdy,
  input  logic             agent_sel,
  output logic             mismatch,
  output logic             mis_is_addr
);
  logic exp_par_q;
  logic chk_addr_q;
  logic chk_data_q;
  logic data_beat;

  assign data_beat = irdy && trdy && agent_sel && !addr_phase;

  // Hold the recomputed parity and its qualifier until the parity bit arrives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_par_q  <= 1'b0;
      chk_addr_q <= 1'b0;
      chk_data_q <= 1'b0;
    end else begin
      exp_par_q  <= even_par(ad_in, cbe_in);
      chk_addr_q <= addr_phase;
      chk_data_q <= data_beat;
    end
  end

  assign mismatch    = (chk_addr_q || chk_data_q) && (exp_par_q != par_in);
  assign mis_is_addr = chk_addr_q;
endmodule

// File: rtl/pci_dpe_status.sv
module pci_dpe_status (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch,
  input  logic mis_is_addr,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic perr_pulse,
  output logic perr_is_addr,
  output logic dpe_status
);
  logic clr_req;
  assign clr_req = stat_wr && stat_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_pulse   <= 1'b0;
      perr_is_addr <= 1'b0;
      dpe_status   <= 1'b0;
    end else begin
      perr_pulse   <= mismatch;
      perr_is_addr <= mismatch && mis_is_addr;
      if (mismatch)     dpe_status <= 1'b1;  // a new error wins over a clear
      else if (clr_req) dpe_status <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_parity_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_out,
  input  logic [CBE_W-1:0] cbe_out,
  input  logic             ad_oe,
  output logic             par_out,
  output logic             par_oe,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             addr_phase,
  input  logic             irdy,
  input  logic             trdy,
  input  logic             agent_sel,
  input  logic             stat_wr,
  input  logic             stat_wdata,
  output logic             perr_pulse,
  output logic             perr_is_addr,
  output logic             dpe_status
);
  logic mismatch;
  logic mis_is_addr;

  pci_par_gen u_gen (
    .clk(clk), .rst_n(rst_n), .ad_out(ad_out), .cbe_out(cbe_out),
    .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe)
  );

  pci_par_chk u_chk_path (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
    .addr_phase(addr_phase), .irdy(irdy), .trdy(trdy), .agent_sel(agent_sel),
    .mismatch(mismatch), .mis_is_addr(mis_is_addr)
  );

  pci_dpe_status u_stat (
    .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .mis_is_addr(mis_is_addr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .perr_pulse(perr_pulse),
    .perr_is_addr(perr_is_addr), .dpe_status(dpe_status)
  );
endmodule

// File: rtl/pci_parity_checker.sv
module pci_parity_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ad_out,
  input logic [3:0]  cbe_out,
  input logic        ad_oe,
  input logic        par_out,
  input logic        par_oe,
  input logic        addr_phase,
  input logic        irdy,
  input logic        trdy,
  input logic        agent_sel,
  input logic        stat_wr,
  input logic        stat_wdata,
  input logic        perr_pulse,
  input logic        perr_is_addr,
  input logic        dpe_status,
  input logic        mismatch
);
  assert_even_par_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> ($countones({$past(ad_out), $past(cbe_out), par_out}) % 2 == 0));

  assert_oe_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> par_oe);

  assert_oe_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |=> !par_oe);

  assert_no_unqualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_phase || (irdy && trdy && agent_sel)) |=> ##1 !perr_pulse);

  assert_kind_needs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_is_addr |-> perr_pulse);

  assert_pulse_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perr_pulse |-> dpe_status);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dpe_status && !(stat_wr && stat_wdata) |=> dpe_status);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && stat_wdata && !mismatch |=> !dpe_status);

  assert_error_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> dpe_status && perr_pulse);
endmodule

bind pci_parity_unit pci_parity_checker u_checker (
  .clk(clk), .rst_n(rst_n), .ad_out(ad_out), .cbe_out(cbe_out), .ad_oe(ad_oe),
  .par_out(par_out), .par_oe(par_oe), .addr_phase(addr_phase), .irdy(irdy),
  .trdy(trdy), .agent_sel(agent_sel), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
  .perr_pulse(perr_pulse), .perr_is_addr(perr_is_addr), .dpe_status(dpe_status),
  .mismatch(mismatch)
);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_out = '0, ad_in = '0;
  logic [3:0]  cbe_out = '0, cbe_in = '0;
  logic        ad_oe = 0, par_in = 0, addr_phase = 0, irdy = 0, trdy = 0, agent_sel = 0;
  logic        stat_wr = 0, stat_wdata = 0;
  logic        par_out, par_oe, perr_pulse, perr_is_addr, dpe_status;

  int total = 0, bad = 0;
  bit finished = 0;

  // State of the reference model for the receive side
  logic [31:0] h_ad = '0;
  logic [3:0]  h_cbe = '0;
  bit          h_qual = 0, h_addr = 0, h_flip = 0;
  bit          st_exp = 0;

  always #2 clk = ~clk;

  pci_parity_unit u_dut (.*);

  function automatic bit ref_par(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return (ones % 2) == 1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tx_step(input logic [31:0] a, input logic [3:0] c, input bit oe, input string req);
    ad_out = a; cbe_out = c; ad_oe = oe;
    @(posedge clk); @(negedge clk);
    check("R2 par_oe", par_oe, oe);
    if (oe) check(req, par_out, ref_par(a, c));
  endtask

  // One receive beat; par_in carries the parity belonging to the previous beat.
  task automatic rx_step(input logic [31:0] a, input logic [3:0] c, input bit ap, input bit ir,
                         input bit tr, input bit sel, input bit flip, input bit wr, input bit wd);
    bit pulse_exp;
    ad_in = a; cbe_in = c; addr_phase = ap; irdy = ir; trdy = tr; agent_sel = sel;
    par_in = ref_par(h_ad, h_cbe) ^ h_flip;
    stat_wr = wr; stat_wdata = wd;
    @(posedge clk); @(negedge clk);
    pulse_exp = h_qual && h_flip;
    if (pulse_exp) st_exp = 1;
    else if (wr && wd) st_exp = 0;
    if (h_qual) check(h_addr ? "R4 pulse" : "R5 pulse", perr_pulse, pulse_exp);
    else        check("R6 unchecked beat", perr_pulse, 1'b0);
    check(h_addr ? "R4 kind" : "R5 kind", perr_is_addr, pulse_exp && h_addr);
    check(pulse_exp ? "R7/R9 status" : "R8 status", dpe_status, st_exp);
    h_ad = a; h_cbe = c; h_addr = ap; h_flip = flip;
    h_qual = ap || (ir && tr && sel);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R10 par_out", par_out, 1'b0);
    check("R10 par_oe", par_oe, 1'b0);
    check("R10 perr_pulse", perr_pulse, 1'b0);
    check("R10 perr_is_addr", perr_is_addr, 1'b0);
    check("R10 dpe_status", dpe_status, 1'b0);
    rst_n = 1;

    // Drive side: directed lane cases, then random words
    tx_step(32'h0, 4'b0001, 1, "R3 cbe lane");
    tx_step(32'h0, 4'b0000, 1, "R1 all zero");
    tx_step(32'hFFFF_FFFF, 4'b1110, 1, "R1 odd ones");
    tx_step(32'h1, 4'b0000, 0, "R2 disabled");
    for (int k = 0; k < 300; k++)
      tx_step($urandom, 4'($urandom), 1'($urandom), "R1 random");
    ad_oe = 0;

    // Receive side: directed corners
    rx_step(32'h0, 4'b0001, 1, 0, 0, 0, 1, 0, 0);  // address phase, bad parity
    rx_step(32'h0, 4'b1000, 0, 1, 1, 1, 1, 1, 1);  // R4 error + clear same edge -> R9
    rx_step(32'h0, 4'b0000, 0, 1, 1, 0, 1, 0, 0);  // data error (R5) from previous beat
    rx_step(32'h0, 4'b0000, 0, 0, 0, 0, 0, 1, 0);  // R6 previous unselected; R8 write of 0
    rx_step(32'h0, 4'b0000, 0, 0, 0, 0, 0, 1, 1);  // R8 clear takes effect
    rx_step(32'h0, 4'b0000, 0, 0, 0, 0, 0, 0, 0);
    // Random mixed stream
    for (int k = 0; k < 2000; k++)
      rx_step($urandom, 4'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
              ($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 8) == 0, 1'($urandom));
    rx_step(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule